// File: doc/BRIEF.md
# Interrupt Condition Status Unit

This unit gathers four interrupt conditions from a serial peripheral's FIFO ports and shift engine and presents them to software as three readable views: a raw status word, a mask (enable) word and a masked status word. A fourth, write-only location clears the two latched conditions when a 1 is written to their bit. The OR of the masked status drives a single interrupt line.

Two conditions are edge events from the engine, receive overrun and receive timeout. They are held until software clears them. The other two are service requests derived from FIFO occupancy: a receive request when the receive FIFO is at least half full, and a transmit request when the transmit FIFO is at most half full. These are re-evaluated every cycle from the occupancy counts and follow their sources. Because the transmit FIFO is empty out of reset, the raw status comes out of reset with the transmit request already set.

The register selector and write strobe come from an external bus decoder. Read data is a combinational function of the selector and the stored state.

Top module: `intr_status_unit`

## Requirements
- R1: After reset the raw status reads 0x8, the mask reads 0x0, the masked status reads 0x0, and `irq` is low.
- R2: In every view, bit 0 is receive overrun, bit 1 is receive timeout, bit 2 is the receive request and bit 3 is the transmit request. `reg_sel` picks the view: 0 raw status, 1 mask, 2 masked status, 3 clear. Read bits above bit 3 are zero.
- R3: A one-cycle pulse on `ovr_evt` (or `tmo_evt`) sets raw bit 0 (or bit 1) at the next clock edge. The bit stays set after the pulse ends.
- R4: A write with `reg_sel`=3 clears each latched bit (0 or 1) whose `wr_data` bit is 1. A 0 in `wr_data` leaves the bit unchanged, and `wr_data` bits 2 and 3 have no effect.
- R5: If a set pulse and a clearing write reach the same latched bit in one cycle, the bit ends up set.
- R6: Raw bit 2 equals (`rx_count` >= FIFO_DEPTH/2), sampled at the previous clock edge.
- R7: Raw bit 3 equals (`tx_count` <= FIFO_DEPTH/2), sampled at the previous clock edge.
- R8: A write with `reg_sel`=1 stores `wr_data` into the mask at the clock edge. Without such a write the mask holds its value.
- R9: The masked status always reads as raw status AND mask.
- R10: `irq` is high exactly when at least one masked status bit is set.
- R11: Writes with `reg_sel`=0 or 2 change nothing, and the clear location always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_evt | input | 1 | Receive overrun event pulse |
| tmo_evt | input | 1 | Receive timeout event pulse |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| wr_en | input | 1 | Bus write strobe for the selected view |
| reg_sel | input | 2 | View selector for both read and write |
| wr_data | input | 4 | Write data, one bit per condition |
| rd_data | output | DATA_W | Read data of the selected view |
| irq | output | 1 | Combined interrupt line |

## Verification
The bound checker checks the following relations on every cycle:
- a set pulse reaches its latched bit one edge later, even when a clear write arrives in the same cycle;
- a latched bit holds unless it is cleared;
- a clearing write without a set pulse drops the bit;
- the request bits track the occupancy thresholds of the previous edge;
- the mask changes only on its own write;
- `irq` agrees with raw AND mask.

Only the bench's scenarios show the following:
- the reset values;
- the view encoding and the zeroed upper read bits;
- that writes to the raw and masked views and the clear read-back leave no trace at the port.

The bench also sweeps every raw and mask combination and every occupancy count against arithmetic expectations.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int unsigned NUM_COND = 4;
   localparam int unsigned NUM_LATCHED = 2;

   // bit positions, shared by every view
   localparam int unsigned B_OVR = 0;
   localparam int unsigned B_TMO = 1;
   localparam int unsigned B_RXQ = 2;
   localparam int unsigned B_TXQ = 3;

   localparam logic [NUM_COND-1:0] RAW_RESET = 4'b1000;

   typedef enum logic [1:0] {
      SEL_RAW    = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_MASKED = 2'd2,
      SEL_CLEAR  = 2'd3
   } view_sel_e;
endpackage

// File: rtl/isr_sticky_bit.sv
module isr_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/isr_level_bit.sv
module isr_level_bit #(
   parameter int unsigned CNT_W    = 4,
   parameter logic [CNT_W-1:0] THRESH = '0,
   parameter bit          AT_LEAST = 1'b1,
   parameter bit          RST_VAL  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   output logic             q_o
);
   logic hit;

   generate
      if (AT_LEAST) begin : g_ge
         assign hit = (count_i >= THRESH);
      end else begin : g_le
         assign hit = (count_i <= THRESH);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= hit;
   end
endmodule

// File: rtl/isr_rd_mux.sv
module isr_rd_mux
   import isr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [1:0]          sel_i,
   input  logic [NUM_COND-1:0] raw_i,
   input  logic [NUM_COND-1:0] mask_i,
   input  logic [NUM_COND-1:0] masked_i,
   output logic [DATA_W-1:0]   data_o
);
   always_comb begin
      data_o = '0;
      unique case (view_sel_e'(sel_i))
         SEL_RAW:    data_o[NUM_COND-1:0] = raw_i;
         SEL_MASK:   data_o[NUM_COND-1:0] = mask_i;
         SEL_MASKED: data_o[NUM_COND-1:0] = masked_i;
         SEL_CLEAR:  data_o = '0;
         default:    data_o = '0;
      endcase
   end
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
   import isr_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ovr_evt,
   input  logic                tmo_evt,
   input  logic [CNT_W-1:0]    rx_count,
   input  logic [CNT_W-1:0]    tx_count,
   input  logic                wr_en,
   input  logic [1:0]          reg_sel,
   input  logic [3:0]          wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq
);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

   generate
      if (DATA_W < NUM_COND) begin : g_bad_width
         $error("DATA_W must hold all condition bits");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if ((1 << CNT_W) <= FIFO_DEPTH) begin : g_bad_cnt
         $error("CNT_W too narrow for FIFO_DEPTH");
      end
   endgenerate

   logic                wr_mask;
   logic                wr_clear;
   logic [NUM_COND-1:0] raw_q;
   logic [NUM_COND-1:0] mask_q;
   logic [NUM_COND-1:0] masked;
   logic [NUM_LATCHED-1:0] set_vec;

   assign wr_mask  = wr_en && (view_sel_e'(reg_sel) == SEL_MASK);
   assign wr_clear = wr_en && (view_sel_e'(reg_sel) == SEL_CLEAR);
   assign set_vec[B_OVR] = ovr_evt;
   assign set_vec[B_TMO] = tmo_evt;

   // latched engine events
   generate
      for (genvar i = 0; i < NUM_LATCHED; i++) begin : g_latch
         isr_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (wr_clear && wr_data[i]),
            .q_o   (raw_q[i])
         );
      end
   endgenerate

   // FIFO-level service requests
   isr_level_bit #(
      .CNT_W    (CNT_W),
      .THRESH   (HALF),
      .AT_LEAST (1'b1),
      .RST_VAL  (RAW_RESET[B_RXQ])
   ) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (rx_count),
      .q_o     (raw_q[B_RXQ])
   );

   isr_level_bit #(
      .CNT_W    (CNT_W),
      .THRESH   (HALF),
      .AT_LEAST (1'b0),
      .RST_VAL  (RAW_RESET[B_TXQ])
   ) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (tx_count),
      .q_o     (raw_q[B_TXQ])
   );

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wr_data;
   end

   assign masked = raw_q & mask_q;
   assign irq    = |masked;

   isr_rd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i    (reg_sel),
      .raw_i    (raw_q),
      .mask_i   (mask_q),
      .masked_i (masked),
      .data_o   (rd_data)
   );
endmodule

// File: rtl/intr_status_unit_chk.sv
module intr_status_unit_chk #(
   parameter int unsigned CNT_W = 4,
   parameter logic [CNT_W-1:0] HALF = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ovr_evt,
   input logic             tmo_evt,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             wr_en,
   input logic [1:0]       reg_sel,
   input logic [3:0]       wr_data,
   input logic [3:0]       raw_q,
   input logic [3:0]       mask_q,
   input logic             irq
);
   logic clr_w;
   assign clr_w = wr_en && (reg_sel == 2'd3);

   // R3, R5: a set pulse wins even against a clear
   p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> raw_q[0]);
   p_tmo_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> raw_q[1]);
   p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[0] && !(clr_w && wr_data[0])) |=> raw_q[0]);
   p_tmo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[1] && !(clr_w && wr_data[1])) |=> raw_q[1]);
   p_ovr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && wr_data[0] && !ovr_evt) |=> !raw_q[0]);
   p_tmo_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && wr_data[1] && !tmo_evt) |=> !raw_q[1]);
   p_rx_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (raw_q[2] == $past(rx_count >= HALF)));
   p_tx_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (raw_q[3] == $past(tx_count <= HALF)));
   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1) |=> (mask_q == $past(wr_data)));
   p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_sel == 2'd1) |=> $stable(mask_q));
   p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((raw_q & mask_q) != 4'd0));
endmodule

bind intr_status_unit intr_status_unit_chk #(.CNT_W(CNT_W), .HALF(HALF)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ovr_evt  (ovr_evt),
   .tmo_evt  (tmo_evt),
   .rx_count (rx_count),
   .tx_count (tx_count),
   .wr_en    (wr_en),
   .reg_sel  (reg_sel),
   .wr_data  (wr_data),
   .raw_q    (raw_q),
   .mask_q   (mask_q),
   .irq      (irq)
);

// File: tb/tb_intr_status_unit.sv
module tb_intr_status_unit;
   localparam int DEPTH = 8;
   localparam int CW    = 4;
   localparam int HALF  = DEPTH / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ovr_evt = 1'b0, tmo_evt = 1'b0;
   logic [CW-1:0] rx_count = '0, tx_count = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [3:0]    wr_data = '0;
   logic [31:0]   rd_data;
   logic          irq;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   intr_status_unit #(.DATA_W(32), .FIFO_DEPTH(DEPTH), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .tmo_evt(tmo_evt),
      .rx_count(rx_count), .tx_count(tx_count), .wr_en(wr_en),
      .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      reg_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic wr(input logic [1:0] s, input logic [3:0] d);
      wr_en = 1'b1; reg_sel = s; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   logic [31:0] v;

   initial begin
      @(negedge clk);
      #1;
      // R1 reset state
      rd(2'd0, v); check("R1 raw", v, 32'h8);
      rd(2'd1, v); check("R1 mask", v, 32'h0);
      rd(2'd2, v); check("R1 masked", v, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      rd(2'd0, v); check("R7 tx request with empty tx fifo", v, 32'h8);

      // R11: writes to raw/masked ignored; clear reads zero
      wr(2'd0, 4'hF);
      rd(2'd0, v); check("R11 raw write ignored", v, 32'h8);
      wr(2'd2, 4'hF);
      rd(2'd2, v); check("R11 masked write ignored", v, 32'h0);
      rd(2'd1, v); check("R11 mask untouched", v, 32'h0);
      rd(2'd3, v); check("R11 clear reads zero", v, 32'h0);

      // R3: latched events, R2 bit order
      ovr_evt = 1'b1; step(); ovr_evt = 1'b0;
      rd(2'd0, v); check("R3 overrun sets bit0 (R2)", v, 32'h9);
      step(); step();
      rd(2'd0, v); check("R3 overrun held", v, 32'h9);
      tmo_evt = 1'b1; step(); tmo_evt = 1'b0;
      rd(2'd0, v); check("R3 timeout sets bit1 (R2)", v, 32'hB);
      rd(2'd3, v); check("R11 clear reads zero with bits set", v, 32'h0);

      // R4: write-1-to-clear
      wr(2'd3, 4'b0010);
      rd(2'd0, v); check("R4 clear timeout only", v, 32'h9);
      wr(2'd3, 4'b0000);
      rd(2'd0, v); check("R4 zero write no effect", v, 32'h9);
      rx_count = CW'(DEPTH); step();
      wr(2'd3, 4'hF);
      rd(2'd0, v); check("R4 clear leaves level bits", v, 32'hC);
      rx_count = '0; step();

      // R5: set wins over same-cycle clear
      ovr_evt = 1'b1; wr(2'd3, 4'b0001); ovr_evt = 1'b0;
      rd(2'd0, v); check("R5 set wins", v, 32'h9);
      tmo_evt = 1'b1; wr(2'd3, 4'b0011); tmo_evt = 1'b0;
      rd(2'd0, v); check("R5 set wins timeout, overrun cleared", v, 32'hA);
      wr(2'd3, 4'hF);

      // R6 / R7: occupancy sweep
      for (int c = 0; c <= DEPTH; c++) begin
         rx_count = CW'(c);
         tx_count = CW'(DEPTH - c);
         step();
         rd(2'd0, v);
         check("R6 rx request level", {31'd0, v[2]}, {31'd0, (c >= HALF)});
         check("R7 tx request level", {31'd0, v[3]}, {31'd0, ((DEPTH - c) <= HALF)});
      end
      // R6 one-cycle latency
      rx_count = '0; tx_count = CW'(DEPTH);
      #1; rd(2'd0, v); check("R6 latency before edge", {31'd0, v[2]}, 32'd1);
      step();
      rd(2'd0, v); check("R6 follows after edge", v, 32'h0);

      // R8: mask store, upper bits zero
      wr(2'd1, 4'hF);
      rd(2'd1, v); check("R8 mask store", v, 32'hF);
      wr(2'd1, 4'h5);
      rd(2'd1, v); check("R8 mask rewrite", v, 32'h5);
      step();
      rd(2'd1, v); check("R8 mask holds", v, 32'h5);

      // R9 / R10: full raw x mask sweep
      for (int r = 0; r < 16; r++) begin
         for (int m = 0; m < 16; m++) begin
            wr(2'd3, 4'hF);
            ovr_evt  = r[0];
            tmo_evt  = r[1];
            rx_count = r[2] ? CW'(DEPTH) : '0;
            tx_count = r[3] ? '0 : CW'(DEPTH);
            wr(2'd1, 4'(m));
            ovr_evt = 1'b0; tmo_evt = 1'b0;
            rd(2'd0, v); check("R9 raw setup", v, 32'(r));
            rd(2'd2, v); check("R9 masked", v, 32'(r & m));
            check("R10 irq", {31'd0, irq}, {31'd0, ((r & m) != 0)});
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule